// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to sixty-four raw interrupt request lines and offers the highest-priority eligible one to a small CPU as a request plus a source number. Each source has its own control byte that holds a three-bit priority level, a mask bit and a pending flag. A rising edge on a request line latches the pending flag, and it does so even while the source is masked. The request is delivered once the source is unmasked, unless software clears the flag before then.

The mask bits can also be reached through a packed bank with eight sources per byte, so one byte write can mask or unmask a group of eight sources. The bank and the control bytes share the same mask storage. An in-service register keeps one bit per priority level. When the CPU acknowledges a request, the controller clears that source's pending flag and marks its level as in service. A new request is offered only if its level is strictly more urgent than every level currently in service. End-of-interrupt retires the most urgent level that is in service, so handlers can nest.

Software reaches the registers through a 16-bit bus with two byte enables. Reads return data one cycle after the access.

Top module: `prio_intc`

## Requirements
- R1: After reset every source is masked, no flag is pending, every priority level is 7, the in-service register is zero and `irq_req` is low.
- R2: A 0-to-1 transition on `irq_in[n]` sets source n's pending flag, and the flag is visible after the next clock edge. A line that stays high does not set the flag again once software has cleared it.
- R3: A pending source that is masked raises no request. Unmasking it later delivers the request if the flag is still set.
- R4: A write of 0 to bit 7 of a control byte clears the pending flag. If a new rising edge on the same source arrives in the same cycle as that write, the flag stays set.
- R5: Mask bank halfword k (k = 0..3) holds sources 16k..16k+7 in its low byte and sources 16k+8..16k+15 in its high byte, at bit position (source & 7). A 1 masks the source. Each byte enable writes only its own group, so writing 0xFF to a lane masks all eight sources of that group. These bits are the same storage as bit 6 of the control bytes.
- R6: The control byte of source n sits in the low lane of halfword 8+n. Its bit 7 is the pending flag, bit 6 is the mask bit and bits 2:0 are the level. Bits 5:3 and the high lane read as zero.
- R7: The request goes to the pending, unmasked source with the numerically lowest level (level 0 is the most urgent). Ties go to the lowest source number, and `irq_lvl` reports the winner's level.
- R8: A pulse on `irq_ack` while `irq_req` is high clears the pending flag of `irq_id` and sets in-service bit `irq_lvl`. A pulse on `irq_ack` while `irq_req` is low changes nothing.
- R9: While any in-service bit is set, only sources whose level is strictly below the lowest set in-service bit index can request.
- R10: A pulse on `irq_eoi` clears only the lowest-numbered set in-service bit.
- R11: `bus_rdata` presents the addressed register one cycle after a read access. The in-service register reads at halfword 127 in the low lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Halfword address |
| bus_be | input | 2 | Byte enables, bit 0 = low lane |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| irq_in | input | 64 | Raw request lines, edge-sensitive |
| irq_req | output | 1 | Request to the CPU |
| irq_id | output | 6 | Source number of the offered request |
| irq_lvl | output | 3 | Level of the offered request |
| irq_ack | input | 1 | CPU takes the offered request |
| irq_eoi | input | 1 | CPU finishes the current handler |

## Verification
Three things follow one clock edge after their cause: a rising request edge shows up on `irq_req`, `irq_id` and `irq_lvl`; a bus write shows up in the arbitration outputs; and an acknowledge or end-of-interrupt changes which request is offered. Read data is also ready one edge after the read is issued. The bench therefore changes every input just after a falling edge and samples the outputs at the next falling edge, which sits exactly one rising edge later. Cases where two causes land in the same cycle, such as a clearing write meeting a new edge, are driven within one half-cycle window, so their combined effect is checked at that same single-edge point.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int BUS_W    = 16;
    localparam int LANE_W   = 8;
    localparam int PEND_BIT = 7;
    localparam int MASK_BIT = 6;
    localparam int GROUP_W  = 8;
endpackage

// File: rtl/pic_first_set.sv
module pic_first_set #(
    parameter  int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Lowest set index wins; scanning downward leaves the lowest hit last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter  int NSRC = 64,
    parameter  int NLVL = 8,
    localparam int SW   = $clog2(NSRC),
    localparam int LW   = $clog2(NLVL)
) (
    input  logic [NSRC-1:0]         pend,
    input  logic [NSRC-1:0]         mask,
    input  logic [NSRC-1:0][LW-1:0] prio,
    input  logic [NLVL-1:0]         isr,
    output logic                    req,
    output logic [SW-1:0]           id,
    output logic [LW-1:0]           lvl,
    output logic                    busy,
    output logic [LW-1:0]           busy_lvl
);
    logic [NSRC-1:0]            live;
    logic [NLVL-1:0][NSRC-1:0]  cand;
    logic [NLVL-1:0]            lvl_ok;
    logic [NSRC-1:0]            win_vec;
    logic                       lvl_found;
    logic                       src_found;

    assign live = pend & ~mask;

    // Most urgent level currently being serviced.
    pic_first_set #(.W(NLVL)) u_isr_scan (
        .vec   (isr),
        .found (busy),
        .idx   (busy_lvl)
    );

    generate
        for (genvar l = 0; l < NLVL; l++) begin : g_lvl
            for (genvar s = 0; s < NSRC; s++) begin : g_src
                assign cand[l][s] = live[s] && (prio[s] == LW'(l));
            end
            assign lvl_ok[l] = (|cand[l]) && (!busy || (LW'(l) < busy_lvl));
        end
    endgenerate

    pic_first_set #(.W(NLVL)) u_lvl_scan (
        .vec   (lvl_ok),
        .found (lvl_found),
        .idx   (lvl)
    );

    assign win_vec = cand[lvl];

    pic_first_set #(.W(NSRC)) u_src_scan (
        .vec   (win_vec),
        .found (src_found),
        .idx   (id)
    );

    assign req = lvl_found && src_found;
endmodule

// File: rtl/pic_readmux.sv
module pic_readmux
    import pic_pkg::*;
#(
    parameter  int NSRC      = 64,
    parameter  int NLVL      = 8,
    parameter  int AW        = 7,
    parameter  int CTRL_BASE = 8,
    parameter  int ISR_HW    = 127,
    localparam int SW        = $clog2(NSRC),
    localparam int LW        = $clog2(NLVL),
    localparam int MASK_HW   = NSRC / (2 * GROUP_W)
) (
    input  logic [AW-1:0]           addr,
    input  logic [NSRC-1:0]         pend,
    input  logic [NSRC-1:0]         mask,
    input  logic [NSRC-1:0][LW-1:0] prio,
    input  logic [NLVL-1:0]         isr,
    output logic [BUS_W-1:0]        rdata
);
    logic [AW-1:0] ctrl_off;
    logic [SW-1:0] ctrl_idx;
    logic          in_ctrl;

    assign ctrl_off = addr - AW'(CTRL_BASE);
    assign ctrl_idx = ctrl_off[SW-1:0];
    assign in_ctrl  = (addr >= AW'(CTRL_BASE)) && (addr < AW'(CTRL_BASE + NSRC));

    always_comb begin
        rdata = '0;
        for (int h = 0; h < MASK_HW; h++) begin
            if (addr == AW'(h)) begin
                rdata = mask[h*BUS_W +: BUS_W];
            end
        end
        if (in_ctrl) begin
            rdata[PEND_BIT] = pend[ctrl_idx];
            rdata[MASK_BIT] = mask[ctrl_idx];
            rdata[LW-1:0]   = prio[ctrl_idx];
        end
        if (addr == AW'(ISR_HW)) begin
            rdata[NLVL-1:0] = isr;
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
#(
    parameter  int NSRC      = 64,
    parameter  int NLVL      = 8,
    parameter  int CTRL_BASE = 8,
    localparam int SW        = $clog2(NSRC),
    localparam int LW        = $clog2(NLVL),
    localparam int MASK_HW   = NSRC / (2 * GROUP_W),
    localparam int AW        = $clog2(CTRL_BASE + NSRC + 1),
    localparam int ISR_HW    = (1 << AW) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [1:0]       bus_be,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic [NSRC-1:0]  irq_in,
    output logic             irq_req,
    output logic [SW-1:0]    irq_id,
    output logic [LW-1:0]    irq_lvl,
    input  logic             irq_ack,
    input  logic             irq_eoi
);
    typedef struct packed {
        logic [NSRC-1:0]         pend;
        logic [NSRC-1:0]         mask;
        logic [NSRC-1:0][LW-1:0] prio;
        logic [NLVL-1:0]         isr;
        logic [NSRC-1:0]         prev;
        logic [BUS_W-1:0]        rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC-1:0]  pend_q;
    logic [NSRC-1:0]  mask_q;
    logic [NLVL-1:0]  isr_q;
    logic             arb_req;
    logic [SW-1:0]    arb_id;
    logic [LW-1:0]    arb_lvl;
    logic             svc_busy;
    logic [LW-1:0]    svc_lvl;
    logic [BUS_W-1:0] rd_word;
    logic [AW-1:0]    ctrl_off;
    logic [SW-1:0]    ctrl_idx;
    logic             in_ctrl;
    logic             wr_go;
    logic             rd_go;
    logic [NSRC-1:0]  rise;

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;
    assign isr_q  = st_q.isr;

    pic_arbiter #(.NSRC(NSRC), .NLVL(NLVL)) u_arb (
        .pend     (st_q.pend),
        .mask     (st_q.mask),
        .prio     (st_q.prio),
        .isr      (st_q.isr),
        .req      (arb_req),
        .id       (arb_id),
        .lvl      (arb_lvl),
        .busy     (svc_busy),
        .busy_lvl (svc_lvl)
    );

    pic_readmux #(
        .NSRC(NSRC), .NLVL(NLVL), .AW(AW), .CTRL_BASE(CTRL_BASE), .ISR_HW(ISR_HW)
    ) u_rd (
        .addr  (bus_addr),
        .pend  (st_q.pend),
        .mask  (st_q.mask),
        .prio  (st_q.prio),
        .isr   (st_q.isr),
        .rdata (rd_word)
    );

    assign wr_go    = bus_sel && bus_wr;
    assign rd_go    = bus_sel && !bus_wr;
    assign ctrl_off = bus_addr - AW'(CTRL_BASE);
    assign ctrl_idx = ctrl_off[SW-1:0];
    assign in_ctrl  = (bus_addr >= AW'(CTRL_BASE)) && (bus_addr < AW'(CTRL_BASE + NSRC));
    assign rise     = irq_in & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;

        // Packed mask bank: each lane writes one group of eight mask bits.
        for (int h = 0; h < MASK_HW; h++) begin
            if (wr_go && (bus_addr == AW'(h))) begin
                if (bus_be[0]) st_d.mask[h*BUS_W +: LANE_W]          = bus_wdata[LANE_W-1:0];
                if (bus_be[1]) st_d.mask[h*BUS_W + LANE_W +: LANE_W] = bus_wdata[BUS_W-1:LANE_W];
            end
        end

        // Per-source control byte, low lane only.
        if (wr_go && bus_be[0] && in_ctrl) begin
            st_d.pend[ctrl_idx] = bus_wdata[PEND_BIT];
            st_d.mask[ctrl_idx] = bus_wdata[MASK_BIT];
            st_d.prio[ctrl_idx] = bus_wdata[LW-1:0];
        end

        // Retire the most urgent in-service level.
        if (irq_eoi && svc_busy) begin
            st_d.isr[svc_lvl] = 1'b0;
        end

        // Take the offered request.
        if (irq_ack && arb_req) begin
            st_d.pend[arb_id]  = 1'b0;
            st_d.isr[arb_lvl]  = 1'b1;
        end

        // A fresh edge always wins over a clear in the same cycle.
        st_d.pend = st_d.pend | rise;

        if (rd_go) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend  <= '0;
            st_q.mask  <= '1;
            st_q.prio  <= '1;
            st_q.isr   <= '0;
            st_q.prev  <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req   = arb_req;
    assign irq_id    = arb_id;
    assign irq_lvl   = arb_lvl;
    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/pic_intc_chk.sv
module pic_intc_chk #(
    parameter  int NSRC = 64,
    parameter  int NLVL = 8,
    localparam int SW   = $clog2(NSRC),
    localparam int LW   = $clog2(NLVL)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] irq_in,
    input logic            irq_req,
    input logic [SW-1:0]   irq_id,
    input logic [LW-1:0]   irq_lvl,
    input logic            irq_ack,
    input logic            irq_eoi,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] mask,
    input logic [NLVL-1:0] isr
);
    logic [NSRC-1:0] in_prev;
    logic [NSRC-1:0] seen_rise;
    logic [NLVL-1:0] upto_lvl;

    always_ff @(posedge clk) begin
        in_prev <= irq_in;
    end

    assign seen_rise = irq_in & ~in_prev;

    always_comb begin
        for (int l = 0; l < NLVL; l++) begin
            upto_lvl[l] = (LW'(l) <= irq_lvl);
        end
    end

    assert_req_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend[irq_id] && !mask[irq_id]));

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) == '0) |-> !irq_req);

    assert_rise_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rise != '0) |=> ((pend & $past(seen_rise)) == $past(seen_rise)));

    assert_ack_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> isr[$past(irq_lvl)]);

    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !irq_eoi) |=> (isr == $past(isr)));

    assert_svc_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((isr & upto_lvl) == '0));

    assert_eoi_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_eoi && !irq_ack && (isr != '0)) |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

bind prio_intc pic_intc_chk #(.NSRC(NSRC), .NLVL(NLVL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .irq_req (irq_req),
    .irq_id  (irq_id),
    .irq_lvl (irq_lvl),
    .irq_ack (irq_ack),
    .irq_eoi (irq_eoi),
    .pend    (pend_q),
    .mask    (mask_q),
    .isr     (isr_q)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [63:0] irq_in = '0;
    logic        irq_req;
    logic [5:0]  irq_id;
    logic [2:0]  irq_lvl;
    logic        irq_ack = 1'b0;
    logic        irq_eoi = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_req(irq_req),
        .irq_id(irq_id), .irq_lvl(irq_lvl), .irq_ack(irq_ack), .irq_eoi(irq_eoi)
    );

    // {srcA, lvlA, srcB, lvlB, srcC, lvlC, expected winner}
    localparam logic [32:0] TBL [6] = '{
        {6'd3,  3'd5, 6'd10, 3'd2, 6'd40, 3'd6, 6'd10},
        {6'd7,  3'd4, 6'd2,  3'd4, 6'd50, 3'd4, 6'd2},
        {6'd63, 3'd0, 6'd0,  3'd1, 6'd1,  3'd1, 6'd63},
        {6'd20, 3'd3, 6'd21, 3'd3, 6'd19, 3'd7, 6'd20},
        {6'd5,  3'd7, 6'd6,  3'd7, 6'd4,  3'd7, 6'd4},
        {6'd33, 3'd1, 6'd32, 3'd2, 6'd31, 3'd1, 6'd31}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 2'b11;
        @(negedge clk);
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        @(negedge clk); irq_eoi = 1'b1;
        @(negedge clk); irq_eoi = 1'b0;
    endtask

    task automatic raise(input int s);
        @(negedge clk); irq_in[s] = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [6:0] ctl(input int s);
        return 7'(8 + s);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R6 / R11: reset state through the bus
        chk("R1 req", 32'(irq_req), 0);
        rd(ctl(0), v);   chk("R1 R6 ctrl0", 32'(v), 32'h47);
        rd(ctl(63), v);  chk("R1 ctrl63", 32'(v), 32'h47);
        rd(7'd3, v);     chk("R1 R5 maskbank3", 32'(v), 32'hFFFF);
        rd(7'd127, v);   chk("R1 R11 isr", 32'(v), 0);

        // R7: table of three-source contests
        foreach (TBL[i]) begin
            int a, b, c, w;
            logic [2:0] pa, pb, pc, pw;
            a = int'(TBL[i][32:27]); pa = TBL[i][26:24];
            b = int'(TBL[i][23:18]); pb = TBL[i][17:15];
            c = int'(TBL[i][14:9]);  pc = TBL[i][8:6];
            w = int'(TBL[i][5:0]);
            pw = (w == a) ? pa : ((w == b) ? pb : pc);
            wr(ctl(a), 2'b01, {13'd0, pa});
            wr(ctl(b), 2'b01, {13'd0, pb});
            wr(ctl(c), 2'b01, {13'd0, pc});
            @(negedge clk);
            irq_in[a] = 1'b1; irq_in[b] = 1'b1; irq_in[c] = 1'b1;
            @(negedge clk);
            chk("R7 R2 req", 32'(irq_req), 1);
            chk("R7 id", 32'(irq_id), 32'(w));
            chk("R7 lvl", 32'(irq_lvl), 32'(pw));
            irq_in[a] = 1'b0; irq_in[b] = 1'b0; irq_in[c] = 1'b0;
            wr(ctl(a), 2'b01, 16'h0047);
            wr(ctl(b), 2'b01, 16'h0047);
            wr(ctl(c), 2'b01, 16'h0047);
            chk("R7 cleanup", 32'(irq_req), 0);
        end

        // R5: packed bank aliases control mask bits, lanes independent
        wr(7'd1, 2'b01, 16'h0000);
        rd(ctl(18), v);  chk("R5 alias ctrl18", 32'(v), 32'h07);
        wr(ctl(25), 2'b01, 16'h0003);
        rd(7'd1, v);     chk("R5 bank1 view", 32'(v), 32'hFD00);
        wr(7'd1, 2'b01, 16'hABFF);
        rd(7'd1, v);     chk("R5 lane0 FF", 32'(v), 32'hFDFF);
        wr(7'd1, 2'b10, 16'hFF00);
        rd(7'd1, v);     chk("R5 lane1 FF", 32'(v), 32'hFFFF);

        // R3: masked pending latches, delivered after unmask via bank
        raise(9);
        chk("R3 masked quiet", 32'(irq_req), 0);
        irq_in[9] = 1'b0;
        rd(ctl(9), v);   chk("R3 R6 pend latched", 32'(v), 32'hC7);
        wr(7'd0, 2'b10, 16'hFD00);
        chk("R3 unmask req", 32'(irq_req), 1);
        chk("R3 unmask id", 32'(irq_id), 9);
        chk("R3 unmask lvl", 32'(irq_lvl), 7);

        // R8: acknowledge
        pulse_ack();
        chk("R8 req after ack", 32'(irq_req), 0);
        rd(7'd127, v);   chk("R8 R11 isr", 32'(v), 32'h80);
        rd(ctl(9), v);   chk("R8 pend cleared", 32'(v), 32'h07);
        pulse_eoi();
        rd(7'd127, v);   chk("R10 isr empty", 32'(v), 0);

        // R9: in-service blocking and nesting
        wr(ctl(12), 2'b01, 16'h0002);
        wr(ctl(13), 2'b01, 16'h0005);
        wr(ctl(14), 2'b01, 16'h0002);
        raise(12);
        chk("R9 id12", 32'(irq_id), 12);
        pulse_ack();
        raise(13);
        chk("R9 lower blocked", 32'(irq_req), 0);
        raise(14);
        chk("R9 equal blocked", 32'(irq_req), 0);
        pulse_eoi();
        chk("R9 R7 after eoi req", 32'(irq_req), 1);
        chk("R9 R7 after eoi id", 32'(irq_id), 14);
        pulse_ack();
        chk("R9 still blocked", 32'(irq_req), 0);
        wr(ctl(13), 2'b01, 16'h0081);
        chk("R9 more urgent req", 32'(irq_req), 1);
        chk("R9 more urgent id", 32'(irq_id), 13);
        chk("R9 more urgent lvl", 32'(irq_lvl), 1);
        pulse_ack();
        rd(7'd127, v);   chk("R9 nested isr", 32'(v), 32'h06);
        pulse_eoi();
        rd(7'd127, v);   chk("R10 lowest cleared", 32'(v), 32'h04);
        pulse_eoi();
        rd(7'd127, v);   chk("R10 all retired", 32'(v), 0);
        irq_in[12] = 1'b0; irq_in[13] = 1'b0; irq_in[14] = 1'b0;

        // R8: ack with no request is ignored
        pulse_ack();
        rd(7'd127, v);   chk("R8 idle ack", 32'(v), 0);

        // R4: clear meets new edge in the same cycle
        wr(ctl(30), 2'b01, 16'h0007);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ctl(30); bus_be = 2'b01; bus_wdata = 16'h0007;
        irq_in[30] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(ctl(30), v);  chk("R4 edge wins", 32'(v), 32'h87);
        wr(ctl(30), 2'b01, 16'h0007);
        rd(ctl(30), v);  chk("R4 R2 clear held level", 32'(v), 32'h07);
        chk("R2 no retrigger", 32'(irq_req), 0);
        irq_in[30] = 1'b0;

        // R6: high lane and bits 5:3 read zero
        wr(ctl(40), 2'b11, 16'hFF3D);
        rd(ctl(40), v);  chk("R6 layout", 32'(v), 32'h05);
        chk("R6 unmasked no pend", 32'(irq_req), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule